// File: doc/BRIEF.md
# USB Suspend and Wake-up Controller

This block handles the low-power behaviour of a USB device controller. It watches a decoded line-state code from the bus. When the bus has been idle long enough, it enters suspend, flags the entry and, if software allows it, shuts off the oscillator and PLL enables. Resume or reset signalling during suspend turns the clocks back on. The block waits for the oscillator to report ready and then checks the line again. If the line has dropped back to idle, the burst was a false wake: the block returns to suspend without a word. If the signalling persists, it is a real wake. The wake is flagged and, for a bus reset, a separate reset-start flag is set in the same cycle.

The flags drive two interrupt lines. The suspend-class line carries suspend entry and wake-up, and the event-class line carries reset start. A separate stop-mode tracker models the chip's clock release. When the CPU requests stop, the clock-ready output drops. It comes back only after the suspend-class line has asserted and a programmable settle count has run out.

Top module: `usb_susp_wake_ctl`

## Requirements
- R1: The line code on `line_state` is 2'b00 bus active, 2'b01 idle, 2'b10 resume signalling and 2'b11 reset signalling. From the running state, IDLE_CYC consecutive idle cycles (default 8) enter suspend and set `susp_sts` on the IDLE_CYC-th clock edge.
- R2: While suspended with `clk_ctl_en` high, `osc_en` and `pll_en` are low. With `clk_ctl_en` low, both stay high in every state.
- R3: In suspend, resume or reset code raises `osc_en` on the next edge. Line checking starts only on the edge after `osc_rdy` is seen high. In the default variant, `pll_en` is high only when both `osc_en` and `osc_rdy` are high.
- R4: An idle code seen during the post-restart check returns the block to suspend (clocks gated again when allowed) and sets no status bit.
- R5: Non-idle code held for DET_CYC consecutive check cycles (default 4) sets `wake_sts` on the DET_CYC-th edge after the check begins, and the block returns to running. The code 2'b00 in suspend does not start a restart.
- R6: If the code on the confirming cycle is 2'b11, `rst_sts` is set in the same cycle as `wake_sts`. Otherwise `rst_sts` stays clear.
- R7: `susp_int` = `susp_irq_en` and (`susp_sts` or `wake_sts`). `evt_int` = `rst_irq_en` and `rst_sts`. A clear enable keeps its line low while the status bits stay readable.
- R8: Status bits stay set until a one is written to the clear strobe `flag_clr`: bit 0 clears `susp_sts`, bit 1 `wake_sts`, bit 2 `rst_sts`. A set and a clear in the same cycle leave the bit set.
- R9: A `stop_req` pulse while `cpu_clk_rdy` is high drops it on the next edge. The first edge with `susp_int` high loads `settle_cnt` (16 bits) into a down-counter. `cpu_clk_rdy` returns on the edge after the counter reaches zero, `settle_cnt`+1 edges after the load.
- R10: A non-idle code before IDLE_CYC idle cycles have accumulated restarts the idle count, so no suspend is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state | input | 2 | Decoded bus line code (R1 encoding) |
| clk_ctl_en | input | 1 | Allows the block to gate oscillator and PLL |
| susp_irq_en | input | 1 | Enable for the suspend-class interrupt line |
| rst_irq_en | input | 1 | Enable for the reset-start interrupt line |
| flag_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| stop_req | input | 1 | CPU request to enter stop mode |
| settle_cnt | input | 16 | Clock-stabilization count loaded at stop release |
| osc_rdy | input | 1 | Oscillator stable indication |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| susp_int | output | 1 | Suspend-class interrupt (suspend entry, wake-up) |
| evt_int | output | 1 | Event-class interrupt (bus reset start) |
| susp_sts | output | 1 | Suspend-entry status bit |
| wake_sts | output | 1 | Wake-up status bit |
| rst_sts | output | 1 | Bus-reset-start status bit |
| cpu_clk_rdy | output | 1 | CPU and peripheral clock ready |

## Verification
The wake path is driven with three burst shapes from suspend. The first is a one-cycle resume or reset glitch that falls back to idle, which must give a silent return to suspend. The second is held resume, which must set the wake flag alone. The third is held reset, which must set the wake and reset flags together. Random mixes of clock-control and interrupt enables separate gated from ungated clocks and masked from unmasked lines. Directed runs interrupt the idle count one cycle short, time the check window and the settle count to the exact edge, and collide a clear with a new suspend entry.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
   typedef enum logic [1:0] {
      LS_ACTIVE = 2'b00,
      LS_IDLE   = 2'b01,
      LS_RESUME = 2'b10,
      LS_RESET  = 2'b11
   } line_e;

   typedef enum logic [1:0] {
      ST_RUN,
      ST_SUSP,
      ST_WAKE,
      ST_DET
   } pm_state_e;

   typedef struct packed {
      logic rst;
      logic wake;
      logic susp;
   } pm_ev_t;
endpackage

// File: rtl/usb_susp_fsm.sv
module usb_susp_fsm
   import usb_susp_pkg::*;
#(
   parameter int IDLE_CYC = 8,
   parameter int DET_CYC  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line_state,
   input  logic       clk_ctl_en,
   input  logic       osc_rdy,
   output logic       osc_en,
   output pm_ev_t     ev,
   output pm_state_e  state
);
   localparam int IW = $clog2(IDLE_CYC + 1);
   localparam int DW = $clog2(DET_CYC + 1);
   localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);
   localparam logic [DW-1:0] DET_LAST  = DW'(DET_CYC - 1);

   line_e           ls;
   pm_state_e       nxt;
   logic [IW-1:0]   idle_cnt;
   logic [DW-1:0]   det_cnt;

   assign ls = line_e'(line_state);

   always_comb begin
      nxt = state;
      ev  = '0;
      unique case (state)
         ST_RUN: begin
            if (ls == LS_IDLE && idle_cnt == IDLE_LAST) begin
               nxt     = ST_SUSP;
               ev.susp = 1'b1;
            end
         end
         ST_SUSP: begin
            if (ls == LS_RESUME || ls == LS_RESET) nxt = ST_WAKE;
         end
         ST_WAKE: begin
            if (osc_rdy) nxt = ST_DET;
         end
         ST_DET: begin
            if (ls == LS_IDLE) begin
               nxt = ST_SUSP;
            end else if (det_cnt == DET_LAST) begin
               nxt     = ST_RUN;
               ev.wake = 1'b1;
               ev.rst  = (ls == LS_RESET);
            end
         end
         default: nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RUN;
         idle_cnt <= '0;
         det_cnt  <= '0;
      end else begin
         state    <= nxt;
         idle_cnt <= (state == ST_RUN && ls == LS_IDLE && nxt == ST_RUN)
                     ? idle_cnt + 1'b1 : '0;
         det_cnt  <= (state == ST_DET && nxt == ST_DET) ? det_cnt + 1'b1 : '0;
      end
   end

   assign osc_en = !(state == ST_SUSP && clk_ctl_en);

   // R10: suspend is only ever entered from running on an idle line
   p_susp_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUSP && $past(state) == ST_RUN) |-> $past(ls == LS_IDLE));

   // R3: the check window opens only after the oscillator reported ready
   p_det_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DET && $past(state) == ST_WAKE) |-> $past(osc_rdy));

   // R4: leaving the check for suspend never produces an event
   p_false_wake_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DET && nxt == ST_SUSP) |-> (ev == '0));
endmodule

// File: rtl/usb_susp_flags.sv
module usb_susp_flags
   import usb_susp_pkg::*;
#(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pm_ev_t           ev,
   input  logic [NFLAG-1:0] flag_clr,
   input  logic             susp_irq_en,
   input  logic             rst_irq_en,
   output logic [NFLAG-1:0] sts,
   output logic             susp_int,
   output logic             evt_int
);
   logic [NFLAG-1:0] set_v;
   assign set_v = {ev.rst, ev.wake, ev.susp};

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sts[i] <= 1'b0;
         else        sts[i] <= set_v[i] | (sts[i] & ~flag_clr[i]);
      end

      // R8: a bit holds unless cleared
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(sts[i]) && !$past(flag_clr[i])) |-> sts[i]);

      // R8: a new event wins over a clear in the same cycle
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(set_v[i]) |-> sts[i]);
   end

   assign susp_int = susp_irq_en & (sts[0] | sts[1]);
   assign evt_int  = rst_irq_en & sts[2];
endmodule

// File: rtl/usb_settle_timer.sv
module usb_settle_timer #(
   parameter int SETTLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stop_req,
   input  logic                wake_line,
   input  logic [SETTLE_W-1:0] load_val,
   output logic                cpu_rdy
);
   logic                rdy_q;
   logic                counting;
   logic [SETTLE_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q    <= 1'b1;
         counting <= 1'b0;
         cnt      <= '0;
      end else if (rdy_q) begin
         counting <= 1'b0;
         if (stop_req) rdy_q <= 1'b0;
      end else if (!counting) begin
         if (wake_line) begin
            cnt      <= load_val;
            counting <= 1'b1;
         end
      end else if (cnt == '0) begin
         rdy_q    <= 1'b1;
         counting <= 1'b0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign cpu_rdy = rdy_q;

   // R9: ready returns only after the count has run out
   p_rdy_after_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_q) |-> $past(counting && cnt == '0));

   // R9: stop is held until a wake line starts the count
   p_stop_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rdy_q && !counting) && !$past(wake_line)) |-> !rdy_q);
endmodule

// File: rtl/usb_susp_wake_ctl.sv
module usb_susp_wake_ctl
   import usb_susp_pkg::*;
#(
   parameter int IDLE_CYC      = 8,
   parameter int DET_CYC       = 4,
   parameter int SETTLE_W      = 16,
   parameter bit PLL_AFTER_OSC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          line_state,
   input  logic                clk_ctl_en,
   input  logic                susp_irq_en,
   input  logic                rst_irq_en,
   input  logic [2:0]          flag_clr,
   input  logic                stop_req,
   input  logic [SETTLE_W-1:0] settle_cnt,
   input  logic                osc_rdy,
   output logic                osc_en,
   output logic                pll_en,
   output logic                susp_int,
   output logic                evt_int,
   output logic                susp_sts,
   output logic                wake_sts,
   output logic                rst_sts,
   output logic                cpu_clk_rdy
);
   localparam int NFLAG = 3;

   if (IDLE_CYC < 2) begin : g_bad_idle
      $error("IDLE_CYC must be at least 2");
   end
   if (DET_CYC < 1) begin : g_bad_det
      $error("DET_CYC must be at least 1");
   end
   if (SETTLE_W < 1 || SETTLE_W > 32) begin : g_bad_settle
      $error("SETTLE_W must lie in 1..32");
   end

   pm_ev_t           ev;
   pm_state_e        state;
   logic [NFLAG-1:0] sts;

   usb_susp_fsm #(
      .IDLE_CYC (IDLE_CYC),
      .DET_CYC  (DET_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_state (line_state),
      .clk_ctl_en (clk_ctl_en),
      .osc_rdy    (osc_rdy),
      .osc_en     (osc_en),
      .ev         (ev),
      .state      (state)
   );

   usb_susp_flags #(
      .NFLAG (NFLAG)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .flag_clr    (flag_clr),
      .susp_irq_en (susp_irq_en),
      .rst_irq_en  (rst_irq_en),
      .sts         (sts),
      .susp_int    (susp_int),
      .evt_int     (evt_int)
   );

   usb_settle_timer #(
      .SETTLE_W (SETTLE_W)
   ) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_req  (stop_req),
      .wake_line (susp_int),
      .load_val  (settle_cnt),
      .cpu_rdy   (cpu_clk_rdy)
   );

   if (PLL_AFTER_OSC) begin : g_pll_seq
      assign pll_en = osc_en & osc_rdy;
      // R3: the PLL never runs ahead of the oscillator
      p_pll_after_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
         pll_en |-> (osc_en && osc_rdy));
   end else begin : g_pll_par
      assign pll_en = osc_en;
   end

   assign susp_sts = sts[0];
   assign wake_sts = sts[1];
   assign rst_sts  = sts[2];

   // R2: clocks are gated only with clock control allowed
   p_gate_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en) |-> clk_ctl_en);

   // R6: reset start never appears without a wake-up
   p_rst_with_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_sts) |-> wake_sts);

   // R7: a masked reset source keeps its line low
   p_evt_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_irq_en |-> !evt_int);
endmodule

// File: tb/test_usb_susp_wake_ctl.sv
module test_usb_susp_wake_ctl;
   localparam int IDLE_CYC = 8;
   localparam int DET_CYC  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  line_state = 2'b00;
   logic        clk_ctl_en = 1'b1;
   logic        susp_irq_en = 1'b1;
   logic        rst_irq_en = 1'b1;
   logic [2:0]  flag_clr = 3'b000;
   logic        stop_req = 1'b0;
   logic [15:0] settle_cnt = 16'd0;
   logic        osc_rdy = 1'b0;
   logic        osc_en, pll_en, susp_int, evt_int;
   logic        susp_sts, wake_sts, rst_sts, cpu_clk_rdy;

   int total = 0;
   int bad = 0;
   logic [2:0] osc_dly = 3'b000;

   always #5 clk = ~clk;

   usb_susp_wake_ctl #(.IDLE_CYC(IDLE_CYC), .DET_CYC(DET_CYC)) i_usb_susp_wake_ctl (
      .clk(clk), .rst_n(rst_n), .line_state(line_state), .clk_ctl_en(clk_ctl_en),
      .susp_irq_en(susp_irq_en), .rst_irq_en(rst_irq_en), .flag_clr(flag_clr),
      .stop_req(stop_req), .settle_cnt(settle_cnt), .osc_rdy(osc_rdy),
      .osc_en(osc_en), .pll_en(pll_en), .susp_int(susp_int), .evt_int(evt_int),
      .susp_sts(susp_sts), .wake_sts(wake_sts), .rst_sts(rst_sts),
      .cpu_clk_rdy(cpu_clk_rdy)
   );

   // oscillator model: ready three cycles after enable, drops at once when off
   initial begin
      forever begin
         @(negedge clk);
         if (!osc_en) osc_dly = 3'b000;
         else         osc_dly = {osc_dly[1:0], 1'b1};
         osc_rdy = osc_dly[2];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [2:0] exp_flags(input int kind);
      // bit2 reset, bit1 wake, bit0 suspend
      if (kind == 0) return 3'b000;
      if (kind == 2) return 3'b110;
      return 3'b010;
   endfunction

   task automatic clear_all();
      flag_clr = 3'b111;
      step(1);
      flag_clr = 3'b000;
   endtask

   task automatic enter_susp();
      line_state = 2'b01;
      step(IDLE_CYC);
      chk("R1 suspend entry", {31'd0, susp_sts}, 32'd1);
   endtask

   task automatic wait_wake(input logic [1:0] code);
      line_state = code;
      for (int k = 0; k < 40 && !wake_sts; k++) step(1);
      line_state = 2'b00;
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(5);
      // reset state
      chk("R2 reset osc_en", {31'd0, osc_en}, 32'd1);
      chk("R3 reset pll_en", {31'd0, pll_en}, 32'd1);
      chk("R8 reset flags", {29'd0, rst_sts, wake_sts, susp_sts}, 32'd0);
      chk("R9 reset cpu ready", {31'd0, cpu_clk_rdy}, 32'd1);

      // R10: idle run broken one short of the limit
      line_state = 2'b01;
      step(IDLE_CYC - 1);
      chk("R10 no suspend short idle", {31'd0, susp_sts}, 32'd0);
      line_state = 2'b00;
      step(1);
      line_state = 2'b01;
      step(IDLE_CYC - 1);
      chk("R10 count restarted", {31'd0, susp_sts}, 32'd0);
      step(1);
      chk("R1 suspend on last idle edge", {31'd0, susp_sts}, 32'd1);
      chk("R7 suspend line", {31'd0, susp_int}, 32'd1);
      chk("R2 osc gated", {31'd0, osc_en}, 32'd0);
      chk("R2 pll gated", {31'd0, pll_en}, 32'd0);

      // R5: active code in suspend does nothing
      line_state = 2'b00;
      step(3);
      chk("R5 active ignored in suspend", {31'd0, osc_en}, 32'd0);
      clear_all();
      chk("R8 clear", {29'd0, rst_sts, wake_sts, susp_sts}, 32'd0);

      // R4: one-cycle resume glitch
      line_state = 2'b10;
      step(1);
      line_state = 2'b01;
      chk("R3 osc restart", {31'd0, osc_en}, 32'd1);
      chk("R3 pll waits for ready", {31'd0, pll_en}, 32'd0);
      step(10);
      chk("R4 back to gated", {31'd0, osc_en}, 32'd0);
      chk("R4 no flags", {29'd0, rst_sts, wake_sts, susp_sts}, 32'd0);

      // R5: exact confirmation window on held resume
      line_state = 2'b10;
      for (int k = 0; k < 20 && !pll_en; k++) step(1);
      step(DET_CYC);
      chk("R5 not yet confirmed", {31'd0, wake_sts}, 32'd0);
      step(1);
      chk("R5 wake confirmed", {31'd0, wake_sts}, 32'd1);
      chk("R6 no reset on resume", {31'd0, rst_sts}, 32'd0);
      line_state = 2'b00;

      // R8: clear colliding with a new suspend entry
      flag_clr = 3'b010;
      step(1);
      flag_clr = 3'b000;
      line_state = 2'b01;
      step(IDLE_CYC - 1);
      chk("R8 flag still clear", {31'd0, susp_sts}, 32'd0);
      flag_clr = 3'b001;
      step(1);
      flag_clr = 3'b000;
      chk("R8 set wins over clear", {31'd0, susp_sts}, 32'd1);
      flag_clr = 3'b001;
      step(1);
      flag_clr = 3'b000;
      chk("R8 clear alone", {31'd0, susp_sts}, 32'd0);

      // R6: held reset
      wait_wake(2'b11);
      chk("R6 wake and reset", {30'd0, rst_sts, wake_sts}, 32'd3);
      chk("R7 event line", {31'd0, evt_int}, 32'd1);
      susp_irq_en = 1'b0;
      rst_irq_en = 1'b0;
      step(1);
      chk("R7 masked suspend line", {31'd0, susp_int}, 32'd0);
      chk("R7 masked event line", {31'd0, evt_int}, 32'd0);
      chk("R7 status kept", {30'd0, rst_sts, wake_sts}, 32'd3);
      susp_irq_en = 1'b1;
      rst_irq_en = 1'b1;
      clear_all();

      // R2: clock control disabled
      clk_ctl_en = 1'b0;
      enter_susp();
      step(3);
      chk("R2 clocks kept running", {30'd0, osc_en, pll_en}, 32'd3);
      wait_wake(2'b10);
      clk_ctl_en = 1'b1;
      clear_all();

      // R9: stop release with settle counts 5 and 0
      for (int s = 0; s < 2; s++) begin
         int n;
         int k;
         n = (s == 0) ? 5 : 0;
         settle_cnt = 16'(n);
         stop_req = 1'b1;
         step(1);
         stop_req = 1'b0;
         chk("R9 stop drops ready", {31'd0, cpu_clk_rdy}, 32'd0);
         enter_susp();
         k = 0;
         while (!cpu_clk_rdy && k < 50) begin
            step(1);
            k++;
         end
         chk("R9 settle edges", 32'(k), 32'(n + 2));
         wait_wake(2'b10);
         clear_all();
      end

      // random mix
      begin
         int unused_seed;
         logic in_run;
         unused_seed = $urandom(32'h1d2c);
         in_run = 1'b1;
         for (int it = 0; it < 24; it++) begin
            int kind;
            logic [2:0] e;
            clk_ctl_en  = 1'($urandom_range(0, 1));
            susp_irq_en = 1'($urandom_range(0, 1));
            rst_irq_en  = 1'($urandom_range(0, 1));
            kind = $urandom_range(0, 2);
            if (in_run) begin
               enter_susp();
               chk("R7 random suspend line", {31'd0, susp_int}, {31'd0, susp_irq_en});
               chk("R2 random gating", {31'd0, osc_en}, {31'd0, !clk_ctl_en});
            end
            clear_all();
            if (kind == 0) begin
               line_state = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b11;
               step(1);
               line_state = 2'b01;
               step(12);
               chk("R4 random false wake", {31'd0, osc_en}, {31'd0, !clk_ctl_en});
               in_run = 1'b0;
            end else begin
               wait_wake((kind == 2) ? 2'b11 : 2'b10);
               step(1);
               in_run = 1'b1;
            end
            e = exp_flags(kind);
            chk(kind == 2 ? "R6 random flags" : "R5 random flags",
                {29'd0, rst_sts, wake_sts, susp_sts}, {29'd0, e});
            chk("R7 random lines", {30'd0, evt_int, susp_int},
                {30'd0, rst_irq_en & e[2], susp_irq_en & (e[1] | e[0])});
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule